// File: doc/BRIEF.md
# Masked Packed FP32 Multiply Lane Unit

This block multiplies two vectors of IEEE-754 single-precision numbers element by element. The vector holds 4, 8 or 16 elements of 32 bits, for 128, 256 or 512 bits. An encoding-class input selects one of three behaviours. The masked class supports a per-lane write mask, scalar broadcast of the second operand and a per-operation rounding override. The non-destructive class always computes every lane inside the vector length. The legacy class is 128 bits wide, and its destination doubles as the first source.

Lanes that the mask switches off either keep the old destination element (merge) or become zero (zero mode). Lanes above the vector length are cleared in the masked and non-destructive classes and kept in the legacy class. The result is registered and appears one cycle after an input pulse, together with a valid strobe. Five sticky exception flags collect the events of every computed lane until reset.

Top module: `pfmul_masked`

## Requirements
- R1: Each computed lane returns the correctly rounded IEEE-754 binary32 product of its two elements, with subnormal inputs and results handled in full.
- R2: `rc_global` selects the rounding mode: 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R3: `rc_override` replaces `rc_global` only when all of the following hold: the class is masked (`enc_class[1]`=1), `vlen[1]`=1 (512 bits), `bcast`=1 and `src2_mem`=0. In every other case `rc_global` applies.
- R4: When the class is masked and both `bcast` and `src2_mem` are 1, every lane uses `src2[31:0]` as its second element. Otherwise lane j uses `src2[32j+31:32j]`.
- R5: In the masked class with `mask_en`=1, a lane whose `mask` bit is 0 is not computed. It takes `dst_old` for that lane when `zero_mode`=0 and zero when `zero_mode`=1. With `mask_en`=0, or in any other class, the mask has no effect.
- R6: The vector length is set by `vlen`: 00 gives 4 lanes, 01 gives 8 lanes, and 1x gives 16 lanes in the masked class and 8 lanes in the non-destructive class (`enc_class`=01). In these two classes, result bits at and above the vector length are zero.
- R7: In the legacy class (`enc_class`=00), lanes 0 to 3 are always computed, mask and broadcast are ignored, and `result[511:128]` equals `dst_old[511:128]`.
- R8: Flag bits are [0] invalid, [1] subnormal operand, [2] overflow, [3] underflow, [4] inexact. On overflow the lane sets overflow and inexact. It returns infinity when rounding to nearest, the largest finite value when rounding toward zero, and for the directed modes infinity or the largest finite value according to the sign. Underflow is set when the result is below the normal range before rounding and is inexact.
- R9: A signalling NaN input sets invalid and is returned quieted. A NaN in the first source takes priority over one in the second. Infinity times zero returns 0xFFC00000 and sets invalid.
- R10: Flags are the OR, kept until reset, over computed lanes only. Masked-off lanes and lanes above the vector length add nothing.
- R11: `out_valid` is high exactly in the cycle after `in_valid`. `result` changes only then. After reset, `out_valid`, `result` and `flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| enc_class | input | 2 | 00 legacy, 01 non-destructive, 1x masked |
| vlen | input | 2 | Vector length code |
| bcast | input | 1 | Broadcast / rounding-override bit |
| src2_mem | input | 1 | Second source came from memory |
| mask_en | input | 1 | A write mask is in use |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges |
| mask | input | 16 | Per-lane write mask |
| rc_global | input | 2 | Global rounding mode |
| rc_override | input | 2 | Per-operation rounding mode |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Registered result vector |
| flags | output | 5 | Sticky exception flags |

## Verification
The assertions check on every cycle the one-cycle valid timing, that the result holds between operations, that the flags never clear outside reset, and the handling of the destination bits above 128 in both the legacy and the short-vector forms. They also check that an all-zero mask in zero mode gives an all-zero result and leaves the flags unchanged. The bench scenarios alone show the arithmetic: the rounding direction of inexact products, the overflow and underflow results, and the NaN priority. Only the scenarios can show the rounding-override conditions, broadcast selection, merge masking, and the exclusion of flags from inactive lanes.

// File: rtl/pfmul_pkg.sv
package pfmul_pkg;
  localparam int LANE_W    = 32;
  localparam int MAX_LANES = 16;
  localparam int VEC_W     = LANE_W * MAX_LANES;
  localparam int FLAG_W    = 5;
  localparam int BASE_LANES = 4;  // lanes in the shortest vector

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INX = 4;

  localparam logic [LANE_W-1:0] QNAN_DEFAULT = 32'hFFC0_0000;
endpackage

// File: rtl/fp32_mul_lane.sv
module fp32_mul_lane
  import pfmul_pkg::*;
(
  input  logic [LANE_W-1:0] op_a,
  input  logic [LANE_W-1:0] op_b,
  input  logic [1:0]        rmode,
  output logic [LANE_W-1:0] prod,
  output logic [FLAG_W-1:0] exc
);
  localparam int MW = 24;
  localparam int PW = 2 * MW;

  logic              sgn, a_zero, b_zero, a_sub, b_sub, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
  logic [7:0]        ea_eff, eb_eff;
  logic [PW-1:0]     mp, pn, sh;
  logic [5:0]        lead, dc;
  logic signed [10:0] e_big;
  logic [10:0]       dnum;
  logic              lost, grd, stk, inc, inexact, tiny, ovf;
  logic [7:0]        expf;
  logic [31:0]       rnd;
  rmode_e            rm;

  always_comb begin
    rm     = rmode_e'(rmode);
    sgn    = op_a[31] ^ op_b[31];
    a_zero = (op_a[30:23] == 8'd0) && (op_a[22:0] == 23'd0);
    b_zero = (op_b[30:23] == 8'd0) && (op_b[22:0] == 23'd0);
    a_sub  = (op_a[30:23] == 8'd0) && (op_a[22:0] != 23'd0);
    b_sub  = (op_b[30:23] == 8'd0) && (op_b[22:0] != 23'd0);
    a_inf  = (op_a[30:23] == 8'hFF) && (op_a[22:0] == 23'd0);
    b_inf  = (op_b[30:23] == 8'hFF) && (op_b[22:0] == 23'd0);
    a_nan  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
    b_nan  = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 23'd0);
    a_snan = a_nan && !op_a[22];
    b_snan = b_nan && !op_b[22];
    ea_eff = (op_a[30:23] == 8'd0) ? 8'd1 : op_a[30:23];
    eb_eff = (op_b[30:23] == 8'd0) ? 8'd1 : op_b[30:23];
    mp     = {{MW{1'b0}}, (op_a[30:23] != 8'd0), op_a[22:0]} *
             {{MW{1'b0}}, (op_b[30:23] != 8'd0), op_b[22:0]};
    lead = 6'd0;
    for (int i = 0; i < PW; i++) begin
      if (mp[i]) lead = 6'(i);
    end
    e_big = $signed({5'd0, lead}) + $signed({3'd0, ea_eff}) + $signed({3'd0, eb_eff}) - 11'sd173;
    pn    = mp << (6'd47 - lead);
    tiny  = (e_big < 11'sd1);
    dnum  = 11'(11'sd1 - e_big);
    dc    = (dnum > 11'd48) ? 6'd48 : dnum[5:0];
    if (tiny) begin
      sh   = pn >> dc;
      lost = |(pn & ~({PW{1'b1}} << dc));
      expf = 8'd0;
    end else begin
      sh   = pn;
      lost = 1'b0;
      expf = e_big[7:0];
    end
    grd     = sh[23];
    stk     = (|sh[22:0]) | lost;
    inexact = grd | stk;
    unique case (rm)
      RM_NEAR: inc = grd & (stk | sh[24]);
      RM_DOWN: inc = inexact & sgn;
      RM_UP:   inc = inexact & ~sgn;
      default: inc = 1'b0;
    endcase
    rnd = {1'b0, expf, sh[46:24]} + {31'd0, inc};
    ovf = (e_big > 11'sd254) || (rnd[30:23] == 8'hFF);

    exc           = '0;
    exc[FL_DEN]   = (a_sub | b_sub) & ~(a_nan | b_nan);
    if (a_nan) begin
      prod        = op_a | 32'h0040_0000;
      exc[FL_INV] = a_snan | b_snan;
    end else if (b_nan) begin
      prod        = op_b | 32'h0040_0000;
      exc[FL_INV] = b_snan;
    end else if ((a_inf & b_zero) | (b_inf & a_zero)) begin
      prod        = QNAN_DEFAULT;
      exc[FL_INV] = 1'b1;
    end else if (a_inf | b_inf) begin
      prod = {sgn, 8'hFF, 23'd0};
    end else if (a_zero | b_zero) begin
      prod = {sgn, 31'd0};
    end else if (ovf) begin
      exc[FL_OVF] = 1'b1;
      exc[FL_INX] = 1'b1;
      if (rm == RM_ZERO || (rm == RM_DOWN && !sgn) || (rm == RM_UP && sgn))
        prod = {sgn, 8'hFE, 23'h7FFFFF};
      else
        prod = {sgn, 8'hFF, 23'd0};
    end else begin
      prod        = {sgn, rnd[30:0]};
      exc[FL_INX] = inexact;
      exc[FL_UNF] = tiny & inexact;
    end
  end
endmodule

// File: rtl/pfmul_ctrl.sv
module pfmul_ctrl
  import pfmul_pkg::*;
#(
  parameter int LANES = MAX_LANES
) (
  input  logic [1:0]       enc_class,
  input  logic [1:0]       vlen,
  input  logic             bcast,
  input  logic             src2_mem,
  input  logic             mask_en,
  input  logic [LANES-1:0] mask,
  input  logic [1:0]       rc_global,
  input  logic [1:0]       rc_override,
  output logic [1:0]       rm_eff,
  output logic [LANES-1:0] lane_in_vl,
  output logic [LANES-1:0] lane_act,
  output logic             use_bcast,
  output logic             keep_upper
);
  localparam int MID_LANES = 2 * BASE_LANES;

  logic is_legacy, is_masked;
  int   n_lanes;

  always_comb begin
    is_legacy  = (enc_class == 2'b00);
    is_masked  = enc_class[1];
    keep_upper = is_legacy;
    use_bcast  = is_masked & bcast & src2_mem;
    rm_eff     = (is_masked && vlen[1] && bcast && !src2_mem) ? rc_override : rc_global;
    if (is_legacy || vlen == 2'b00) n_lanes = BASE_LANES;
    else if (vlen == 2'b01 || !is_masked) n_lanes = MID_LANES;
    else n_lanes = LANES;
    for (int j = 0; j < LANES; j++) lane_in_vl[j] = (j < n_lanes);
    lane_act = lane_in_vl & ((is_masked && mask_en) ? mask : {LANES{1'b1}});
  end
endmodule

// File: rtl/pfmul_masked.sv
module pfmul_masked
  import pfmul_pkg::*;
#(
  parameter int LANES = MAX_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              enc_class,
  input  logic [1:0]              vlen,
  input  logic                    bcast,
  input  logic                    src2_mem,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic [LANES-1:0]        mask,
  input  logic [1:0]              rc_global,
  input  logic [1:0]              rc_override,
  input  logic [LANES*LANE_W-1:0] src1,
  input  logic [LANES*LANE_W-1:0] src2,
  input  logic [LANES*LANE_W-1:0] dst_old,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result,
  output logic [FLAG_W-1:0]       flags
);
  localparam int VW = LANES * LANE_W;

  logic [1:0]        rm_eff;
  logic [LANES-1:0]  lane_in_vl, lane_act;
  logic              use_bcast, keep_upper;
  logic [LANE_W-1:0] prod [LANES];
  logic [FLAG_W-1:0] exc  [LANES];
  logic [VW-1:0]     res_d, res_q;
  logic [FLAG_W-1:0] flag_d, flag_q;
  logic              vld_q;

  pfmul_ctrl #(.LANES(LANES)) u_ctrl (
    .enc_class(enc_class), .vlen(vlen), .bcast(bcast), .src2_mem(src2_mem),
    .mask_en(mask_en), .mask(mask), .rc_global(rc_global), .rc_override(rc_override),
    .rm_eff(rm_eff), .lane_in_vl(lane_in_vl), .lane_act(lane_act),
    .use_bcast(use_bcast), .keep_upper(keep_upper)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] b_sel;
    assign b_sel = use_bcast ? src2[LANE_W-1:0] : src2[j*LANE_W +: LANE_W];
    fp32_mul_lane u_mul (
      .op_a(src1[j*LANE_W +: LANE_W]), .op_b(b_sel), .rmode(rm_eff),
      .prod(prod[j]), .exc(exc[j])
    );
  end

  always_comb begin
    flag_d = flag_q;
    for (int j = 0; j < LANES; j++) begin
      if (lane_act[j]) begin
        res_d[j*LANE_W +: LANE_W] = prod[j];
        flag_d = flag_d | exc[j];
      end else if (lane_in_vl[j]) begin
        res_d[j*LANE_W +: LANE_W] = zero_mode ? '0 : dst_old[j*LANE_W +: LANE_W];
      end else begin
        res_d[j*LANE_W +: LANE_W] = keep_upper ? dst_old[j*LANE_W +: LANE_W] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      flag_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        flag_q <= flag_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flags     = flag_q;
endmodule

// File: rtl/pfmul_masked_chk.sv
module pfmul_masked_chk
  import pfmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        enc_class,
  input logic [1:0]        vlen,
  input logic              mask_en,
  input logic              zero_mode,
  input logic [15:0]       mask,
  input logic [511:0]      dst_old,
  input logic              out_valid,
  input logic [511:0]      result,
  input logic [FLAG_W-1:0] flags
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid missing"); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("spurious valid"); // R11
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)) else $error("result moved"); // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flags & $past(flags)) == $past(flags))) else $error("flag cleared"); // R10
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class != 2'b00 && vlen == 2'b00) |=> (result[511:128] == '0))
    else $error("tail not zero"); // R6
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'b00) |=> (result[511:128] == $past(dst_old[511:128])))
    else $error("legacy upper changed"); // R7
  AST_ZERO_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class[1] && mask_en && zero_mode && mask == 16'd0) |=> (result == '0))
    else $error("zero mask result"); // R5
  AST_MASKED_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class[1] && mask_en && mask == 16'd0) |=> (flags == $past(flags)))
    else $error("flags from masked lanes"); // R10
endmodule

bind pfmul_masked pfmul_masked_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_class(enc_class), .vlen(vlen),
  .mask_en(mask_en), .zero_mode(zero_mode), .mask(mask), .dst_old(dst_old),
  .out_valid(out_valid), .result(result), .flags(flags)
);

// File: tb/pfmul_masked_tb.sv
`timescale 1ns/1ps
module pfmul_masked_tb;
  logic clk = 1'b0;
  logic rst_n, in_valid, bcast, src2_mem, mask_en, zero_mode;
  logic [1:0] enc_class, vlen, rc_global, rc_override;
  logic [15:0] mask;
  logic [511:0] src1, src2, dst_old, result;
  logic out_valid;
  logic [4:0] flags;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] A [16], B [16], D [16];
  logic [4:0] exp_sticky;
  logic [511:0] last_res;

  always #5 clk = ~clk;

  pfmul_masked u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_class(enc_class), .vlen(vlen),
    .bcast(bcast), .src2_mem(src2_mem), .mask_en(mask_en), .zero_mode(zero_mode),
    .mask(mask), .rc_global(rc_global), .rc_override(rc_override), .src1(src1),
    .src2(src2), .dst_old(dst_old), .out_valid(out_valid), .result(result), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected products of the operand pairs used, worked out by hand.
  task automatic lane_ref(input logic [31:0] a, b, input logic [1:0] rm,
                          output logic [31:0] r, output logic [4:0] f);
    case ({a, b})
      {32'h40000000, 32'h40400000}: begin r = 32'h40C00000; f = 5'h00; end
      {32'h3FC00000, 32'hC0000000}: begin r = 32'hC0400000; f = 5'h00; end
      {32'h3F800001, 32'h3F800001}: begin r = (rm == 2'd2) ? 32'h3F800003 : 32'h3F800002; f = 5'h10; end
      {32'h7F000000, 32'h40000000}: begin r = rm[0] ? 32'h7F7FFFFF : 32'h7F800000; f = 5'h14; end
      {32'h00800001, 32'h3F000000}: begin r = (rm == 2'd2) ? 32'h00400001 : 32'h00400000; f = 5'h18; end
      {32'h00000001, 32'h4B000000}: begin r = 32'h00800000; f = 5'h02; end
      {32'h7F800001, 32'h3F800000}: begin r = 32'h7FC00001; f = 5'h01; end
      {32'h7F800000, 32'h00000000}: begin r = 32'hFFC00000; f = 5'h01; end
      {32'h7FC00005, 32'hFFC00007}: begin r = 32'h7FC00005; f = 5'h00; end
      {32'h80000000, 32'h40000000}: begin r = 32'h80000000; f = 5'h00; end
      default: begin r = 32'h0; f = 5'h0; $display("bench: unknown pair %h %h", a, b); end
    endcase
  endtask

  task automatic fill(input logic [31:0] a, b);
    for (int j = 0; j < 16; j++) begin
      A[j] = a; B[j] = b; D[j] = 32'h5A5A0000 | j;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_sticky = '0;
  endtask

  task automatic do_op(input string tag, input logic [1:0] enc, vl, input logic bc, mem, men, zm,
                       input logic [15:0] mk, input logic [1:0] rcg, rco);
    logic [511:0] expv;
    logic [31:0] r, bsel;
    logic [4:0] f;
    logic [1:0] rm;
    int nl;
    bit act;
    rm = (enc[1] && vl[1] && bc && !mem) ? rco : rcg;
    if (enc == 2'b00 || vl == 2'b00) nl = 4;
    else if (vl == 2'b01 || !enc[1]) nl = 8;
    else nl = 16;
    for (int j = 0; j < 16; j++) begin
      bsel = (enc[1] && bc && mem) ? B[0] : B[j];
      act = (j < nl) && (!(enc[1] && men) || mk[j]);
      if (act) begin
        lane_ref(A[j], bsel, rm, r, f);
        expv[j*32 +: 32] = r;
        exp_sticky |= f;
      end else if (j < nl) expv[j*32 +: 32] = zm ? 32'h0 : D[j];
      else expv[j*32 +: 32] = (enc == 2'b00) ? D[j] : 32'h0;
    end
    @(negedge clk);
    enc_class = enc; vlen = vl; bcast = bc; src2_mem = mem; mask_en = men; zero_mode = zm;
    mask = mk; rc_global = rcg; rc_override = rco;
    for (int j = 0; j < 16; j++) begin
      src1[j*32 +: 32] = A[j]; src2[j*32 +: 32] = B[j]; dst_old[j*32 +: 32] = D[j];
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {"R11 valid ", tag}, {511'd0, out_valid}, 512'd1);
    chk(result === expv, {tag, " result"}, result, expv);
    chk(flags === exp_sticky, {tag, " flags"}, {507'd0, flags}, {507'd0, exp_sticky});
    last_res = result;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; enc_class = 2'b10; vlen = 2'b10; bcast = 1'b0;
    src2_mem = 1'b0; mask_en = 1'b0; zero_mode = 1'b0; mask = '0; rc_global = '0;
    rc_override = '0; src1 = '0; src2 = '0; dst_old = '0; exp_sticky = '0;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0 && result === '0 && flags === '0, "R11 reset state", result, 512'd0);
    rst_n = 1'b1;

    // R1: full width, two operand pairs interleaved
    fill(32'h40000000, 32'h40400000);
    for (int j = 1; j < 16; j += 2) begin A[j] = 32'h3FC00000; B[j] = 32'hC0000000; end
    A[6] = 32'h80000000; B[6] = 32'h40000000;
    do_op("R1 exact products", 2'b10, 2'b10, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    // R11: idle cycle, no valid, result held
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle valid", {511'd0, out_valid}, 512'd0);
    chk(result === last_res, "R11 result held", result, last_res);

    // R6: vector-length tails
    do_op("R6 masked 128", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    do_op("R6 masked 256", 2'b10, 2'b01, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    do_op("R6 nondestructive 1x is 256", 2'b01, 2'b10, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);

    // R2: rounding modes on an inexact product
    do_reset();
    fill(32'h3F800001, 32'h3F800001);
    do_op("R2 nearest", 2'b10, 2'b10, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    do_op("R2 up", 2'b10, 2'b10, 0, 0, 0, 0, 16'h0, 2'd2, 2'd0);
    do_op("R2 zero", 2'b10, 2'b10, 0, 0, 0, 0, 16'h0, 2'd3, 2'd2);

    // R3: override only with 512, bit set, register source
    do_op("R3 override taken", 2'b10, 2'b10, 1, 0, 0, 0, 16'h0, 2'd0, 2'd2);
    do_op("R3 no override at 256", 2'b10, 2'b01, 1, 0, 0, 0, 16'h0, 2'd0, 2'd2);
    do_op("R3 no override memory", 2'b10, 2'b10, 1, 1, 0, 0, 16'h0, 2'd0, 2'd2);
    do_op("R3 no override nondestructive", 2'b01, 2'b10, 1, 0, 0, 0, 16'h0, 2'd0, 2'd2);

    // R4: broadcast from lane 0 of the second source
    fill(32'h40000000, 32'h3FC00000);
    B[0] = 32'h40400000;
    do_op("R4 broadcast", 2'b10, 2'b10, 1, 1, 0, 0, 16'h0, 2'd0, 2'd2);
    fill(32'h40000000, 32'h40400000);
    B[1] = 32'h3F800000; A[1] = 32'h7F800001;
    do_op("R4 no broadcast from register", 2'b10, 2'b10, 1, 0, 0, 0, 16'h0, 2'd0, 2'd0);

    // R5: merge, zero, and ignored mask
    fill(32'h40000000, 32'h40400000);
    do_op("R5 merge", 2'b10, 2'b10, 0, 0, 1, 0, 16'hA5A5, 2'd0, 2'd0);
    do_op("R5 zero", 2'b10, 2'b10, 0, 0, 1, 1, 16'h3C0F, 2'd0, 2'd0);
    do_op("R5 all masked zero", 2'b10, 2'b10, 0, 0, 1, 1, 16'h0000, 2'd0, 2'd0);
    do_op("R5 mask off", 2'b10, 2'b10, 0, 0, 0, 1, 16'h0000, 2'd0, 2'd0);
    do_op("R5 nondestructive ignores mask", 2'b01, 2'b01, 0, 0, 1, 1, 16'h0000, 2'd0, 2'd0);

    // R7: legacy class
    do_op("R7 legacy", 2'b00, 2'b10, 1, 1, 1, 1, 16'h0000, 2'd0, 2'd0);

    // R8: overflow, underflow, subnormal operand
    do_reset();
    fill(32'h40000000, 32'h40400000);
    A[0] = 32'h7F000000; B[0] = 32'h40000000;
    A[1] = 32'h00800001; B[1] = 32'h3F000000;
    A[2] = 32'h00000001; B[2] = 32'h4B000000;
    do_op("R8 nearest", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    do_op("R8 toward zero", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd3, 2'd0);
    do_op("R8 up", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd2, 2'd0);
    do_op("R8 down", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd1, 2'd0);

    // R9: NaN rules
    do_reset();
    fill(32'h40000000, 32'h40400000);
    A[0] = 32'h7F800001; B[0] = 32'h3F800000;
    A[1] = 32'h7F800000; B[1] = 32'h00000000;
    A[2] = 32'h7FC00005; B[2] = 32'hFFC00007;
    do_op("R9 nan cases", 2'b10, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);

    // R10: inactive lanes add no flags; flags persist
    do_reset();
    fill(32'h40000000, 32'h40400000);
    A[0] = 32'h7F000000; B[0] = 32'h40000000;
    do_op("R10 masked lane no flag", 2'b10, 2'b10, 0, 0, 1, 0, 16'hFFFE, 2'd0, 2'd0);
    fill(32'h40000000, 32'h40400000);
    A[5] = 32'h7F000000; B[5] = 32'h40000000;
    do_op("R10 tail lane no flag", 2'b01, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    A[0] = 32'h3F800001; B[0] = 32'h3F800001;
    do_op("R10 flag raised", 2'b01, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);
    fill(32'h40000000, 32'h40400000);
    do_op("R10 flag kept", 2'b01, 2'b00, 0, 0, 0, 0, 16'h0, 2'd0, 2'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule